// File: doc/BRIEF.md
# Jacobi Four-Neighbour Relaxation Engine

This block holds a two-dimensional grid of signed fixed-point values in two equal on-chip buffers and runs Jacobi relaxation sweeps over it. In each sweep every interior cell of the destination buffer receives the average of its north, south, west and east neighbours, taken from the source buffer. The outermost ring of cells passes through unchanged. After each sweep the two buffers trade roles, so the next sweep reads what the previous one wrote.

A host fills the grid through a simple address/data port while the engine is idle. It then pulses `start` with a sweep count on `iters`. The engine answers with a one-cycle `done` pulse after the last write of the last sweep. The same port then reads back the newest generation of the grid. Cell (r, c) lives at address r*COLS + c.

Top module: `jacobi_relax`

## Requirements
- R1: After a sweep, each interior cell (row 1..ROWS-2, column 1..COLS-2) holds floor((N+S+W+E)/4) of its four neighbours in the previous generation, using signed two's-complement arithmetic that cannot overflow.
- R2: Cells in row 0, row ROWS-1, column 0 and column COLS-1 keep their values across any number of sweeps.
- R3: A start with `iters` = n > 0 performs n sweeps. Each sweep uses the previous sweep's result as its input. Readout afterwards returns the result of the n-th sweep.
- R4: A sweep visits cells row by row, with the column index varying fastest, one cell per clock. `done` rises exactly n*ROWS*COLS clock edges after the edge that samples `start`.
- R5: `start` is ignored while sweeps are in progress. It neither restarts the run nor changes the sweep count.
- R6: `done` is high for exactly one cycle per accepted start.
- R7: A start with `iters` = 0 raises `done` on the cycle after the sampling edge and leaves the grid unchanged.
- R8: While idle, a host write to address r*COLS+c is returned by a read of the same address. `host_rdata` is a combinational read of the newest buffer. Host writes issued during a sweep are ignored.
- R9: After reset `done` is low and every cell reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run of sweeps (sampled only when idle) |
| iters | input | IW | Number of sweeps in the run |
| host_we | input | 1 | Host write strobe (idle only) |
| host_addr | input | AW | Cell address, r*COLS + c |
| host_wdata | input | DW | Signed value to write |
| host_rdata | output | DW | Signed value of the addressed cell in the newest buffer |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The hardest case to reach from the ports is a start pulse that arrives together with a stray host write while a multi-sweep run is already under way. The stimulus injects both partway through the first sweep and uses a different sweep count and junk data. The run's length and final grid must then match a run without the injection. Rounding of negative sums is also easy to miss with random data. Directed grids therefore place sums of -1, -3 and -5 next to interior cells.

// File: rtl/jacobi_relax.sv
module jacobi_relax #(
  parameter int ROWS = 6,
  parameter int COLS = 5,
  parameter int DW   = 12,
  parameter int IW   = 4,
  parameter int AW   = $clog2(ROWS*COLS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [IW-1:0]        iters,
  input  logic                 host_we,
  input  logic [AW-1:0]        host_addr,
  input  logic signed [DW-1:0] host_wdata,
  output logic signed [DW-1:0] host_rdata,
  output logic                 done
);
  localparam int CELLS = ROWS * COLS;
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);

  logic signed [DW-1:0] buf0 [CELLS];
  logic signed [DW-1:0] buf1 [CELLS];
  logic          sel, busy;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [IW-1:0] left;
  logic [AW-1:0] cur;
  logic signed [DW-1:0] nv, sv, wv, ev, cv, wr_val;
  logic signed [DW+1:0] sum;

  wire last_col = (col == CW'(COLS-1));
  wire last_row = (row == RW'(ROWS-1));
  wire last     = busy && last_col && last_row;
  wire interior = (row != '0) && !last_row && (col != '0) && !last_col;

  assign cur = AW'(row) * AW'(COLS) + AW'(col);

  always_comb begin
    nv = '0; sv = '0; wv = '0; ev = '0;
    cv = sel ? buf1[cur] : buf0[cur];
    if (interior) begin
      nv = sel ? buf1[cur - AW'(COLS)] : buf0[cur - AW'(COLS)];
      sv = sel ? buf1[cur + AW'(COLS)] : buf0[cur + AW'(COLS)];
      wv = sel ? buf1[cur - AW'(1)]    : buf0[cur - AW'(1)];
      ev = sel ? buf1[cur + AW'(1)]    : buf0[cur + AW'(1)];
    end
  end

  assign sum    = (DW+2)'(nv) + (DW+2)'(sv) + (DW+2)'(wv) + (DW+2)'(ev);
  assign wr_val = interior ? DW'(sum >>> 2) : cv;

  assign host_rdata = sel ? buf1[host_addr] : buf0[host_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) begin
        buf0[i] <= '0;
        buf1[i] <= '0;
      end
      sel  <= 1'b0;
      busy <= 1'b0;
      row  <= '0;
      col  <= '0;
      left <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (host_we && (int'(host_addr) < CELLS)) begin
          if (sel) buf1[host_addr] <= host_wdata;
          else     buf0[host_addr] <= host_wdata;
        end
        if (start) begin
          if (iters == '0) begin
            done <= 1'b1;
          end else begin
            busy <= 1'b1;
            left <= iters;
            row  <= '0;
            col  <= '0;
          end
        end
      end else begin
        if (sel) buf0[cur] <= wr_val;
        else     buf1[cur] <= wr_val;
        if (last_col) begin
          col <= '0;
          row <= last_row ? '0 : row + RW'(1);
        end else begin
          col <= col + CW'(1);
        end
        if (last) begin
          sel  <= ~sel;
          left <= left - IW'(1);
          if (left == IW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4
  raster_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_col) |=> (col == $past(col) + CW'(1)) && (row == $past(row)));

  // R4
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_col && !last_row) |=> (col == '0) && (row == $past(row) + RW'(1)));

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(last_col && last_row)) |=> $stable(sel));

  // R3
  sel_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (sel != $past(sel)));

  // R5
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> busy && $stable(left));

  // R7
  zero_iter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && iters == '0) |=> done && !busy && $stable(sel));
endmodule

// File: tb/sim_jacobi_relax.sv
module sim_jacobi_relax;
  localparam int ROWS = 6, COLS = 5, DW = 12, IW = 4;
  localparam int AW = $clog2(ROWS*COLS);
  localparam int CELLS = ROWS * COLS;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, host_we = 1'b0;
  logic [IW-1:0] iters = '0;
  logic [AW-1:0] host_addr = '0;
  logic signed [DW-1:0] host_wdata = '0;
  logic signed [DW-1:0] host_rdata;
  logic done;

  int checks = 0, errors = 0;
  int model [CELLS];
  int saved [CELLS];

  always #10 clk = ~clk;

  jacobi_relax #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .IW(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .iters(iters),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .done(done));

  function automatic int fdiv4(int s);
    if (s >= 0) return s / 4;
    return -((-s + 3) / 4);
  endfunction

  function automatic bit is_edge(int i);
    int r = i / COLS, c = i % COLS;
    return (r == 0) || (r == ROWS-1) || (c == 0) || (c == COLS-1);
  endfunction

  task automatic model_sweeps(int n);
    int nxt [CELLS];
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < CELLS; i++)
        nxt[i] = is_edge(i) ? model[i]
               : fdiv4(model[i-COLS] + model[i+COLS] + model[i-1] + model[i+1]);
      model = nxt;
    end
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_model();
    for (int i = 0; i < CELLS; i++) begin
      @(negedge clk);
      host_we = 1'b1; host_addr = AW'(i); host_wdata = DW'(model[i]);
    end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic check_grid(string itag, string btag);
    int bad_i = 0, bad_b = 0, fa = 0, fe = 0;
    bit got = 0;
    for (int i = 0; i < CELLS; i++) begin
      @(negedge clk);
      host_addr = AW'(i);
      #1;
      if (int'(host_rdata) != model[i]) begin
        if (is_edge(i)) bad_b++; else bad_i++;
        if (!got) begin fa = int'(host_rdata); fe = model[i]; got = 1; end
      end
    end
    check(bad_i == 0, itag, fa, fe);
    check(bad_b == 0, btag, fa, fe);
  endtask

  task automatic run(int n, bit inject);
    int cnt = 0;
    @(negedge clk);
    start = 1'b1; iters = IW'(n);
    @(negedge clk);
    start = 1'b0;
    while (!done && cnt < 50000) begin
      @(negedge clk);
      cnt++;
      if (inject && cnt == 7) begin
        start = 1'b1; iters = IW'(2**IW - 1);
        host_we = 1'b1; host_addr = AW'(COLS + 1); host_wdata = DW'(-777);
      end else begin
        start = 1'b0; host_we = 1'b0;
      end
    end
    start = 1'b0; host_we = 1'b0;
    // R4 / R5: run length
    check(done && cnt == n * CELLS, inject ? "R5" : "R4", cnt, n * CELLS);
    @(negedge clk);
    // R6
    check(!done, "R6", int'(done), 0);
  endtask

  task automatic rand_model();
    for (int i = 0; i < CELLS; i++)
      model[i] = int'($urandom % (2**DW)) - 2**(DW-1);
  endtask

  initial begin
    repeat (380000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    check(!done, "R9", int'(done), 0);
    for (int i = 0; i < CELLS; i++) model[i] = 0;
    check_grid("R9", "R9");

    // R8 load and read back
    rand_model();
    load_model();
    check_grid("R8", "R8");

    // R1 R2 one sweep
    model_sweeps(0);
    run(1, 0);
    model_sweeps(1);
    check_grid("R1", "R2");

    // R1 directed negative rounding: interior sums -1, -3, -5
    for (int i = 0; i < CELLS; i++) model[i] = 0;
    model[1] = -1;
    model[2] = -3;
    model[3] = -2; model[COLS+4] = -3;
    model[(ROWS-1)*COLS + 2] = 2**(DW-1) - 1;
    model[2*COLS] = -(2**(DW-1));
    load_model();
    run(1, 0);
    model_sweeps(1);
    check_grid("R1", "R2");

    // R1 extremes: all most negative
    for (int i = 0; i < CELLS; i++) model[i] = -(2**(DW-1));
    load_model();
    run(2, 0);
    model_sweeps(2);
    check_grid("R1", "R2");

    // R3 multi-sweep chaining
    rand_model();
    load_model();
    run(3, 0);
    model_sweeps(3);
    check_grid("R3", "R2");

    // R7 zero sweeps
    saved = model;
    @(negedge clk);
    start = 1'b1; iters = '0;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R7", int'(done), 1);
    @(negedge clk);
    check(!done, "R7", int'(done), 0);
    model = saved;
    check_grid("R7", "R7");

    // R5 R8 start and host write injected mid-run
    rand_model();
    load_model();
    run(2, 1);
    model_sweeps(2);
    check_grid("R5", "R8");

    // R3 random runs
    for (int t = 0; t < 4; t++) begin
      int n = 1 + int'($urandom % 4);
      rand_model();
      load_model();
      run(n, 0);
      model_sweeps(n);
      check_grid("R3", "R2");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule